// File: doc/BRIEF.md
# Victim Line Buffer

This block sits next to a direct-mapped first-level cache and keeps a handful of lines that the cache has recently thrown out. Every entry holds a full line address as its tag, the line data, a valid flag and a dirty flag, and any entry can hold any line. When the cache looks up an address it presents the same line address to this buffer in the same cycle. The buffer compares all of its tags at once and answers combinationally, so a buffer hit returns its line in the same cycle as a cache hit would.

When the cache displaces a line, it presents that line on the insert channel. If a lookup hits in the same cycle, the two lines swap. The hit line goes back to the cache, and the displaced line takes the slot that was just vacated. Otherwise the displaced line takes a free slot. If no slot is free, it replaces the least recently used entry. A small age counter per slot tracks recency. A dropped entry that is dirty leaves through a valid/ready writeback channel holding one line. While that line waits for `wb_ready`, `acc_ready` stays low and the lookup/insert request is not taken.

Back-pressure rules: a request with `lk_valid` or `in_valid` high is accepted on a rising clock edge where `acc_ready` is high. The hit response is shown whether or not the request is accepted. `wb_valid`, `wb_addr` and `wb_data` hold steady until a cycle with `wb_ready` high.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is invalid, `wb_valid` is 0 and `acc_ready` is 1; a lookup of any address then misses.
- R2: While `lk_valid` is 1 and `lk_addr` equals the tag of a valid entry, `lk_hit` is 1 in the same cycle, with that entry's data on `lk_data` and its dirty flag on `lk_dirty`. Otherwise `lk_hit`, `lk_dirty` and `lk_data` are all zero.
- R3: An accepted lookup that hits, with no insert in that cycle, removes the entry, so a later lookup of the same address misses.
- R4: An accepted lookup hit together with an insert of a line not held in the buffer places the inserted line in the slot of the hit entry. No entry is dropped and no writeback is raised.
- R5: An accepted insert of a line not held, when some slot is free, fills a free slot and drops nothing.
- R6: An accepted insert of a line not held, with all slots valid and no lookup hit, drops the least recently used entry. An insert makes its line the most recent. A removal makes its slot the oldest.
- R7: When a dropped entry is dirty, `wb_valid` rises after the accepting edge, carrying that entry's address and data. A clean dropped entry raises nothing.
- R8: An insert whose address is already held overwrites that entry's data. The entry's dirty flag becomes the OR of the old and new flags, and the entry becomes the most recent. Nothing is dropped. If a lookup in the same cycle hits a different entry, that entry is removed.
- R9: `acc_ready` equals `!wb_valid || wb_ready`. While `wb_valid` is 1 and `wb_ready` is 0, the writeback address and data do not change.
- R10: While `acc_ready` is 0, a pending lookup or insert changes no entry, but the lookup still reports its hit per R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | ADDR_W | Line address to search |
| lk_hit | output | 1 | Lookup matched a valid entry (same cycle) |
| lk_data | output | DATA_W | Data of the matching entry, zero on miss |
| lk_dirty | output | 1 | Dirty flag of the matching entry |
| in_valid | input | 1 | Displaced line offered for insertion |
| in_addr | input | ADDR_W | Line address of the displaced line |
| in_data | input | DATA_W | Data of the displaced line |
| in_dirty | input | 1 | Displaced line is modified |
| acc_ready | output | 1 | Lookup/insert request accepted at the next edge |
| wb_valid | output | 1 | Writeback line present |
| wb_ready | input | 1 | Writeback consumer takes the line |
| wb_addr | output | ADDR_W | Line address of the written-back line |
| wb_data | output | DATA_W | Data of the written-back line |

## Verification
A lookup and an insert can land on the same edge. The bench provokes this with a lookup that hits while a new displaced line is offered. It checks that the hit line comes back in that cycle and that no writeback follows. It then replays the later lookups and inserts with their expected results, which are derived from a hand-kept recency list. The bench also provokes an insert that must drop a dirty entry while the writeback consumer refuses it. It then judges that the request stalls, the stored lines survive untouched and the held writeback stays fixed until the consumer takes it.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [2:0] {
    INS_NONE  = 3'd0,
    INS_FREE  = 3'd1,
    INS_MERGE = 3'd2,
    INS_SWAP  = 3'd3,
    INS_EVICT = 3'd4
  } ins_kind_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int N  = 4,
  parameter int AW = 26,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         ent_vld,
  input  logic [N-1:0][AW-1:0] ent_tag,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         hit_vec,
  output logic                 hit_any,
  output logic [IW-1:0]        hit_idx
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = ent_vld[g] && (ent_tag[g] == key);
    end
  endgenerate

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int j = 0; j < N; j++) begin
      if (hit_vec[j]) hit_idx = hit_idx | IW'(j);
    end
  end

  // R8 keeps tags unique, so at most one slot can match
  assert_unique_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/vc_age.sv
module vc_age #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          free_en,
  input  logic [IW-1:0] free_idx,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] lru_idx
);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  logic [N-1:0][IW-1:0] age_q, age_mid, age_nxt;
  logic [N-1:0]         seen;

  // removal demotes the slot to oldest, closing the gap above it
  always_comb begin
    age_mid = age_q;
    if (free_en) begin
      for (int j = 0; j < N; j++) begin
        if (IW'(j) == free_idx) age_mid[j] = OLDEST;
        else if (age_q[j] > age_q[free_idx]) age_mid[j] = age_q[j] - 1'b1;
      end
    end
  end

  // insertion promotes the slot to newest, ageing everything younger
  always_comb begin
    age_nxt = age_mid;
    if (touch_en) begin
      for (int j = 0; j < N; j++) begin
        if (IW'(j) == touch_idx) age_nxt[j] = '0;
        else if (age_mid[j] < age_mid[touch_idx]) age_nxt[j] = age_mid[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) age_q[j] <= IW'(j);
    end else begin
      age_q <= age_nxt;
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int j = 0; j < N; j++) begin
      if (age_q[j] == OLDEST) lru_idx = IW'(j);
    end
  end

  always_comb begin
    seen = '0;
    for (int j = 0; j < N; j++) seen[age_q[j]] = 1'b1;
  end

  assert_age_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == N);

  assert_touch_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/vc_store.sv
module vc_store #(
  parameter int N  = 4,
  parameter int AW = 26,
  parameter int DW = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [AW-1:0]        wr_tag,
  input  logic [DW-1:0]        wr_data,
  input  logic                 wr_dirty,
  input  logic                 clr_en,
  input  logic [IW-1:0]        clr_idx,
  output logic [N-1:0]         vld,
  output logic [N-1:0]         dty,
  output logic [N-1:0][AW-1:0] tag,
  output logic [N-1:0][DW-1:0] dat
);
  logic [N-1:0]         vld_q, dty_q;
  logic [N-1:0][AW-1:0] tag_q;
  logic [N-1:0][DW-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
    end else begin
      if (clr_en) begin
        vld_q[clr_idx] <= 1'b0;
        dty_q[clr_idx] <= 1'b0;
      end
      if (wr_en) begin
        vld_q[wr_idx] <= 1'b1;
        dty_q[wr_idx] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  assign vld = vld_q;
  assign dty = dty_q;
  assign tag = tag_q;
  assign dat = dat_q;

  assert_freed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !(wr_en && wr_idx == clr_idx) |=> !vld_q[$past(clr_idx)]);

  assert_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/vc_wb.sv
module vc_wb #(
  parameter int AW = 26,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          wb_ready,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data
);
  logic          v_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= 1'b0;
    else if (load) v_q <= 1'b1;
    else if (wb_ready) v_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      a_q <= ld_addr;
      d_q <= ld_data;
    end
  end

  assign wb_valid = v_q;
  assign wb_addr  = a_q;
  assign wb_data  = d_q;

  assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !wb_valid || wb_ready);
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_dirty,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_dirty,
  output logic              acc_ready,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  import vc_pkg::*;

  logic [ENTRIES-1:0]             st_vld, st_dty;
  logic [ENTRIES-1:0][ADDR_W-1:0] st_tag;
  logic [ENTRIES-1:0][DATA_W-1:0] st_dat;

  logic [ENTRIES-1:0] lk_vec, in_vec;
  logic               lk_any, in_any;
  logic [IW-1:0]      lk_idx, in_idx, free_idx, lru_idx, wr_idx;
  logic               free_any, accept, wr_en, wr_dirty, clr_en, wb_load;
  ins_kind_e          kind;

  vc_match #(.N(ENTRIES), .AW(ADDR_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .ent_vld(st_vld), .ent_tag(st_tag),
    .key(lk_addr), .hit_vec(lk_vec), .hit_any(lk_any), .hit_idx(lk_idx)
  );

  vc_match #(.N(ENTRIES), .AW(ADDR_W)) u_in_match (
    .clk(clk), .rst_n(rst_n), .ent_vld(st_vld), .ent_tag(st_tag),
    .key(in_addr), .hit_vec(in_vec), .hit_any(in_any), .hit_idx(in_idx)
  );

  // swap-out response, same cycle as the lookup
  assign lk_hit   = lk_valid && lk_any;
  assign lk_data  = lk_hit ? st_dat[lk_idx] : '0;
  assign lk_dirty = lk_hit && st_dty[lk_idx];

  assign acc_ready = !wb_valid || wb_ready;
  assign accept    = acc_ready && (lk_valid || in_valid);

  // lowest-numbered free slot
  always_comb begin
    free_idx = '0;
    for (int j = ENTRIES - 1; j >= 0; j--) begin
      if (!st_vld[j]) free_idx = IW'(j);
    end
  end
  assign free_any = !(&st_vld);

  always_comb begin
    if (!in_valid)     kind = INS_NONE;
    else if (in_any)   kind = INS_MERGE;
    else if (lk_hit)   kind = INS_SWAP;
    else if (free_any) kind = INS_FREE;
    else               kind = INS_EVICT;
  end

  always_comb begin
    unique case (kind)
      INS_MERGE: wr_idx = in_idx;
      INS_SWAP:  wr_idx = lk_idx;
      INS_FREE:  wr_idx = free_idx;
      default:   wr_idx = lru_idx;
    endcase
  end

  assign wr_en    = accept && in_valid;
  assign wr_dirty = in_dirty || (kind == INS_MERGE && st_dty[in_idx]);
  assign clr_en   = accept && lk_hit && (kind != INS_SWAP) &&
                    !(kind == INS_MERGE && in_idx == lk_idx);
  assign wb_load  = accept && (kind == INS_EVICT) && st_dty[lru_idx];

  vc_store #(.N(ENTRIES), .AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(in_addr), .wr_data(in_data),
    .wr_dirty(wr_dirty), .clr_en(clr_en), .clr_idx(lk_idx),
    .vld(st_vld), .dty(st_dty), .tag(st_tag), .dat(st_dat)
  );

  vc_age #(.N(ENTRIES)) u_age (
    .clk(clk), .rst_n(rst_n),
    .free_en(clr_en), .free_idx(lk_idx),
    .touch_en(wr_en), .touch_idx(wr_idx),
    .lru_idx(lru_idx)
  );

  vc_wb #(.AW(ADDR_W), .DW(DATA_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .load(wb_load),
    .ld_addr(st_tag[lru_idx]), .ld_data(st_dat[lru_idx]),
    .wb_ready(wb_ready), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  assert_swap_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && kind == INS_SWAP |=> $countones(st_vld) == $past($countones(st_vld)));

  assert_evict_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && kind == INS_EVICT |=> &st_vld);

  assert_stall_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ready |=> $stable(st_vld) && $stable(st_dty));

  assert_wb_from_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid && wb_ready |=> !wb_valid || $past(accept && kind == INS_EVICT));
endmodule

// File: tb/tb_victim_buffer.sv
module tb_victim_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 26;
  localparam int DW = 64;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0, in_valid = 1'b0, in_dirty = 1'b0, wb_ready = 1'b1;
  logic [AW-1:0] lk_addr = '0, in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic          lk_hit, lk_dirty, acc_ready, wb_valid;
  logic [DW-1:0] lk_data, wb_data;
  logic [AW-1:0] wb_addr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  victim_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .lk_dirty(lk_dirty), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .in_dirty(in_dirty), .acc_ready(acc_ready), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        lv;
    logic [15:0] la;
    logic        iv;
    logic [15:0] ia;
    logic [15:0] id;
    logic        idt;
    logic        eh;
    logic [15:0] ed;
    logic        edt;
    logic        ew;
    logic [15:0] ewa;
    logic [15:0] ewd;
  } vec_t;

  // expected results follow a hand-kept recency list, newest first
  localparam vec_t VECS [NV] = '{
    '{4'd5, 1'b0, 16'h00, 1'b1, 16'h10, 16'h1010, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd5, 1'b0, 16'h00, 1'b1, 16'h11, 16'h1111, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd5, 1'b0, 16'h00, 1'b1, 16'h12, 16'h1212, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd5, 1'b0, 16'h00, 1'b1, 16'h13, 16'h1313, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd4, 1'b1, 16'h11, 1'b1, 16'h20, 16'h2020, 1'b0, 1'b1, 16'h1111, 1'b1, 1'b0, 16'h0, 16'h0},
    '{4'd6, 1'b1, 16'h55, 1'b1, 16'h21, 16'h2121, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd6, 1'b0, 16'h00, 1'b1, 16'h22, 16'h2222, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd7, 1'b0, 16'h00, 1'b1, 16'h23, 16'h2323, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, 16'h13, 16'h1313},
    '{4'd6, 1'b1, 16'h10, 1'b0, 16'h00, 16'h0000, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd2, 1'b1, 16'h21, 1'b0, 16'h00, 16'h0000, 1'b0, 1'b1, 16'h2121, 1'b1, 1'b0, 16'h0, 16'h0},
    '{4'd3, 1'b1, 16'h21, 1'b0, 16'h00, 16'h0000, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd5, 1'b0, 16'h00, 1'b1, 16'h24, 16'h2424, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd6, 1'b0, 16'h00, 1'b1, 16'h25, 16'h2525, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd3, 1'b1, 16'h22, 1'b0, 16'h00, 16'h0000, 1'b0, 1'b1, 16'h2222, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd8, 1'b0, 16'h00, 1'b1, 16'h23, 16'h5353, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd5, 1'b0, 16'h00, 1'b1, 16'h26, 16'h2626, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd6, 1'b0, 16'h00, 1'b1, 16'h27, 16'h2727, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd6, 1'b0, 16'h00, 1'b1, 16'h28, 16'h2828, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0},
    '{4'd8, 1'b0, 16'h00, 1'b1, 16'h29, 16'h2929, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, 16'h23, 16'h5353}
  };

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic expect_eq(input string req, input string what,
                           input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic lv, input logic [15:0] la, input logic iv,
                       input logic [15:0] ia, input logic [15:0] id, input logic idt);
    lk_valid = lv;
    lk_addr  = AW'(la);
    in_valid = iv;
    in_addr  = AW'(ia);
    in_data  = DW'(id);
    in_dirty = idt;
  endtask

  task automatic idle();
    drive(1'b0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step_insert(input logic [15:0] ia, input logic [15:0] id, input logic idt);
    drive(1'b0, 16'h0, 1'b1, ia, id, idt);
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1: reset state
    expect_eq("R1", "acc_ready after reset", DW'(acc_ready), 1);
    expect_eq("R1", "wb_valid after reset", DW'(wb_valid), 0);
    drive(1'b1, 16'h10, 1'b0, 16'h0, 16'h0, 1'b0);
    #1;
    expect_eq("R1", "lookup after reset", DW'(lk_hit), 0);
    @(negedge clk);
    idle();

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].lv, VECS[i].la, VECS[i].iv, VECS[i].ia, VECS[i].id, VECS[i].idt);
      #1;
      expect_eq(rname(VECS[i].rq), $sformatf("v%0d lk_hit", i), DW'(lk_hit), DW'(VECS[i].eh));
      if (VECS[i].eh) begin
        expect_eq("R2", $sformatf("v%0d lk_data", i), lk_data, DW'(VECS[i].ed));
        expect_eq("R2", $sformatf("v%0d lk_dirty", i), DW'(lk_dirty), DW'(VECS[i].edt));
      end
      @(posedge clk);
      @(negedge clk);
      expect_eq(VECS[i].ew ? "R7" : rname(VECS[i].rq), $sformatf("v%0d wb_valid", i),
                DW'(wb_valid), DW'(VECS[i].ew));
      if (VECS[i].ew) begin
        expect_eq("R7", $sformatf("v%0d wb_addr", i), DW'(wb_addr), DW'(VECS[i].ewa));
        expect_eq("R7", $sformatf("v%0d wb_data", i), wb_data, DW'(VECS[i].ewd));
      end
    end
    idle();

    // R2: held line 0x28 not reported without lk_valid
    drive(1'b0, 16'h28, 1'b0, 16'h0, 16'h0, 1'b0);
    #1;
    expect_eq("R2", "hit with lk_valid low", DW'(lk_hit), 0);
    expect_eq("R2", "data with lk_valid low", lk_data, 0);
    lk_valid = 1'b1;
    #1;
    expect_eq("R2", "hit on held 0x28", DW'(lk_hit), 1);
    expect_eq("R2", "data on held 0x28", lk_data, DW'(16'h2828));
    lk_valid = 1'b0;
    @(negedge clk);

    // R1: reset in mid-run empties the buffer
    do_reset();
    drive(1'b1, 16'h28, 1'b0, 16'h0, 16'h0, 1'b0);
    #1;
    expect_eq("R1", "lookup after second reset", DW'(lk_hit), 0);
    @(negedge clk);
    idle();

    // R9/R10: writeback back-pressure
    for (int k = 0; k < 4; k++) step_insert(16'h40 + 16'(k), 16'h4040 + 16'(k), 1'b1);
    wb_ready = 1'b0;
    step_insert(16'h44, 16'h4444, 1'b1);
    expect_eq("R7", "wb_valid on dirty drop", DW'(wb_valid), 1);
    expect_eq("R7", "wb_addr on dirty drop", DW'(wb_addr), DW'(16'h40));
    expect_eq("R9", "acc_ready while wb stalled", DW'(acc_ready), 0);
    drive(1'b1, 16'h41, 1'b1, 16'h45, 16'h4545, 1'b1);
    for (int k = 0; k < 3; k++) begin
      #1;
      expect_eq("R10", "hit reported while stalled", DW'(lk_hit), 1);
      @(posedge clk);
      @(negedge clk);
      expect_eq("R9", "wb_addr held", DW'(wb_addr), DW'(16'h40));
      expect_eq("R9", "wb_data held", wb_data, DW'(16'h4040));
      expect_eq("R9", "acc_ready still low", DW'(acc_ready), 0);
    end
    idle();
    wb_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expect_eq("R9", "wb_valid cleared by ready", DW'(wb_valid), 0);
    drive(1'b1, 16'h41, 1'b0, 16'h0, 16'h0, 1'b0);
    #1;
    expect_eq("R10", "line 0x41 kept through stall", DW'(lk_hit), 1);
    lk_addr = AW'(16'h45);
    #1;
    expect_eq("R10", "line 0x45 not taken during stall", DW'(lk_hit), 0);
    idle();
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule